// File: doc/BRIEF.md
# Segment Selector Address Translator

This block turns a logical address, made of a 16-bit segment selector and a 32-bit offset, into a 32-bit linear address. Software first loads six selector registers and the two descriptor-table base registers: one for the global table and one for the task-local table. After that, a request names one of the six selector registers and supplies an offset.

For each request the block reads the selected 8-byte descriptor from memory. It uses a simple synchronous read port and makes two 32-bit reads. It then checks the requested and current privilege levels against the descriptor's level and checks the offset against the segment limit. If both checks pass, it returns base plus offset as a one-cycle valid pulse. Otherwise it returns a one-cycle fault pulse with a code.

A selector whose index is zero is refused at once, and no memory read takes place. The block holds `busy` high while a descriptor fetch is in progress and ignores requests during that time.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `busy`, `lin_valid`, `fault_valid` and `mem_rd_en` are low and `fault_code` is 0.
- R2: A selector write stores `sel_wr_data` in register `sel_wr_idx` (0 to 5). A request on `req_seg` uses the value that register held before the accepting clock edge.
- R3: Selector layout: bits 15:3 hold the descriptor index, bit 2 picks the table (0 = global, 1 = task-local), and bits 1:0 hold the requested privilege level. The descriptor address is the chosen table base plus index times 8.
- R4: The descriptor is fetched as two reads, in the two cycles right after acceptance: the low word at the descriptor address, then the high word at that address plus 4. Read data appears the cycle after `mem_rd_en`. The low word is the segment base. In the high word, bits 19:0 are the limit and bits 22:21 are the descriptor privilege level.
- R5: On success, `lin_valid` pulses for one cycle, three clock edges after the accepting edge. `lin_addr` is base plus offset, modulo 2^32.
- R6: `busy` is high from the accepting edge until the result edge. Requests made while `busy` is high are ignored.
- R7: A selector with index 0, from either table, gives `fault_valid` with code 1 one edge after acceptance, with no memory read and no busy period.
- R8: The effective level is the larger of `cpl` (sampled at acceptance) and the selector's requested level. If the descriptor level is numerically smaller than the effective level, the block signals fault code 2.
- R9: An offset greater than the limit gives fault code 3. An offset equal to the limit is accepted.
- R10: When both the privilege check and the limit check fail, the code is 2. A result never raises `lin_valid` and `fault_valid` together.
- R11: `base_wr_en` loads `base_wr_data` into the task-local base when `base_wr_local` is 1, and into the global base otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr_en | input | 1 | Selector register write strobe |
| sel_wr_idx | input | 3 | Selector register number |
| sel_wr_data | input | 16 | Selector value to write |
| base_wr_en | input | 1 | Table base write strobe |
| base_wr_local | input | 1 | 1 = task-local base, 0 = global base |
| base_wr_data | input | 32 | Table base value |
| cpl | input | 2 | Current privilege level |
| req_valid | input | 1 | Translation request |
| req_seg | input | 3 | Selector register used by the request |
| req_off | input | 32 | Offset within the segment |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | 32 | Descriptor read byte address |
| mem_rd_data | input | 32 | Read data, one cycle after the strobe |
| busy | output | 1 | Descriptor fetch in progress |
| lin_valid | output | 1 | Linear address valid pulse |
| lin_addr | output | 32 | Linear address |
| fault_valid | output | 1 | Fault pulse |
| fault_code | output | 2 | 1 null, 2 privilege, 3 limit |

## Verification
On every cycle, the assertions check the shape of the memory traffic: exactly two reads, with the second at the first address plus 4, and only while `busy` is high. They also check that each busy period ends with exactly one result, that the two result pulses never coincide, and that every fault carries a nonzero code. Only the bench's scenarios can show that the right table and index are chosen and that the privilege and limit comparisons fall on the correct side of their boundaries. The same holds for the wrapping sum, for the checking order when both checks fail, and for requests being dropped while busy.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int ADDR_W  = 32;
    localparam int SEL_W   = 16;
    localparam int IDX_LSB = 3;
    localparam int TI_BIT  = 2;
    localparam int IDX_W   = SEL_W - IDX_LSB;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_NULL  = 2'd1,
        FLT_PRIV  = 2'd2,
        FLT_LIMIT = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_CHECK
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] off;
        logic [1:0]        cpl;
        logic [ADDR_W-1:0] base;
        logic              lin_v;
        logic              flt_v;
        flt_e              code;
        logic [ADDR_W-1:0] lin;
    } ctl_t;
endpackage

// File: rtl/seg_regs.sv
module seg_regs
    import seg_pkg::*;
#(
    parameter int NSEG = 6,
    localparam int SEGW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr_en,
    input  logic [SEGW-1:0]   sel_wr_idx,
    input  logic [SEL_W-1:0]  sel_wr_data,
    input  logic              base_wr_en,
    input  logic              base_wr_local,
    input  logic [ADDR_W-1:0] base_wr_data,
    input  logic [SEGW-1:0]   rd_idx,
    output logic [SEL_W-1:0]  rd_sel,
    output logic [ADDR_W-1:0] glob_base,
    output logic [ADDR_W-1:0] loc_base
);
    logic [SEL_W-1:0]  sel_q [NSEG];
    logic [ADDR_W-1:0] glob_d, glob_q, loc_d, loc_q;

    for (genvar g = 0; g < NSEG; g++) begin : g_sel
        logic [SEL_W-1:0] sel_d;
        always_comb begin
            sel_d = sel_q[g];
            if (sel_wr_en && sel_wr_idx == SEGW'(g)) sel_d = sel_wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) sel_q[g] <= '0;
            else        sel_q[g] <= sel_d;
        end
    end

    always_comb begin
        glob_d = glob_q;
        loc_d  = loc_q;
        if (base_wr_en) begin
            if (base_wr_local) loc_d  = base_wr_data;
            else               glob_d = base_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_q <= '0;
            loc_q  <= '0;
        end else begin
            glob_q <= glob_d;
            loc_q  <= loc_d;
        end
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NSEG; i++)
            if (rd_idx == SEGW'(i)) rd_sel = sel_q[i];
    end

    assign glob_base = glob_q;
    assign loc_base  = loc_q;
endmodule

// File: rtl/seg_desc_eval.sv
module seg_desc_eval
    import seg_pkg::*;
#(
    parameter int LIM_W = 20
) (
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] off,
    input  logic [LIM_W-1:0]  limit,
    input  logic [1:0]        dpl,
    input  logic [1:0]        rpl,
    input  logic [1:0]        cpl,
    output flt_e              code,
    output logic [ADDR_W-1:0] lin
);
    logic [1:0] eff;

    always_comb begin
        eff = (rpl > cpl) ? rpl : cpl;
        if (dpl < eff)
            code = FLT_PRIV;
        else if (off > {{(ADDR_W-LIM_W){1'b0}}, limit})
            code = FLT_LIMIT;
        else
            code = FLT_NONE;
        lin = seg_base + off;
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int NSEG    = 6,
    parameter int LIM_W   = 20,
    parameter int DPL_LSB = 21,
    localparam int SEGW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr_en,
    input  logic [SEGW-1:0]   sel_wr_idx,
    input  logic [SEL_W-1:0]  sel_wr_data,
    input  logic              base_wr_en,
    input  logic              base_wr_local,
    input  logic [ADDR_W-1:0] base_wr_data,
    input  logic [1:0]        cpl,
    input  logic              req_valid,
    input  logic [SEGW-1:0]   req_seg,
    input  logic [ADDR_W-1:0] req_off,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              busy,
    output logic              lin_valid,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              fault_valid,
    output logic [1:0]        fault_code
);
    ctl_t              c_d, c_q;
    logic [SEL_W-1:0]  rd_sel;
    logic [ADDR_W-1:0] glob_base, loc_base, tbl_base, desc_addr, ev_lin;
    flt_e              ev_code;

    seg_regs #(.NSEG(NSEG)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .sel_wr_en(sel_wr_en), .sel_wr_idx(sel_wr_idx), .sel_wr_data(sel_wr_data),
        .base_wr_en(base_wr_en), .base_wr_local(base_wr_local), .base_wr_data(base_wr_data),
        .rd_idx(req_seg), .rd_sel(rd_sel),
        .glob_base(glob_base), .loc_base(loc_base)
    );

    seg_desc_eval #(.LIM_W(LIM_W)) i_eval (
        .seg_base(c_q.base), .off(c_q.off),
        .limit(mem_rd_data[LIM_W-1:0]), .dpl(mem_rd_data[DPL_LSB+1:DPL_LSB]),
        .rpl(c_q.sel[1:0]), .cpl(c_q.cpl),
        .code(ev_code), .lin(ev_lin)
    );

    assign tbl_base  = c_q.sel[TI_BIT] ? loc_base : glob_base;
    assign desc_addr = tbl_base + {{(ADDR_W-SEL_W){1'b0}}, c_q.sel[SEL_W-1:IDX_LSB], 3'b000};

    always_comb begin
        c_d       = c_q;
        c_d.lin_v = 1'b0;
        c_d.flt_v = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.sel = rd_sel;
                    c_d.off = req_off;
                    c_d.cpl = cpl;
                    if (rd_sel[SEL_W-1:IDX_LSB] == '0) begin
                        c_d.flt_v = 1'b1;
                        c_d.code  = FLT_NULL;
                    end else begin
                        c_d.st = ST_RD_LO;
                    end
                end
            end
            ST_RD_LO: c_d.st = ST_RD_HI;
            ST_RD_HI: begin
                c_d.base = mem_rd_data;
                c_d.st   = ST_CHECK;
            end
            ST_CHECK: begin
                c_d.st = ST_IDLE;
                if (ev_code == FLT_NONE) begin
                    c_d.lin_v = 1'b1;
                    c_d.lin   = ev_lin;
                end else begin
                    c_d.flt_v = 1'b1;
                    c_d.code  = ev_code;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign mem_rd_en   = (c_q.st == ST_RD_LO) || (c_q.st == ST_RD_HI);
    assign mem_rd_addr = desc_addr + ((c_q.st == ST_RD_HI) ? ADDR_W'(4) : '0);
    assign busy        = (c_q.st != ST_IDLE);
    assign lin_valid   = c_q.lin_v;
    assign lin_addr    = c_q.lin;
    assign fault_valid = c_q.flt_v;
    assign fault_code  = c_q.code;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_rd_en,
    input logic [31:0] mem_rd_addr,
    input logic        busy,
    input logic        lin_valid,
    input logic        fault_valid,
    input logic [1:0]  fault_code
);
    AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy); // R6
    AST_HI_WORD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |=> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + 32'd4)); // R4
    AST_TWO_READS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |=> !mem_rd_en); // R4
    AST_BUSY_ENDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (lin_valid || fault_valid)); // R6
    AST_NO_DUAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(lin_valid && fault_valid)); // R10
    AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_code != 2'd0)); // R7
    AST_LIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lin_valid |=> !lin_valid); // R5
endmodule

bind seg_xlate seg_xlate_chk i_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .busy(busy), .lin_valid(lin_valid), .fault_valid(fault_valid), .fault_code(fault_code)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr_en = 1'b0;
    logic [2:0]  sel_wr_idx = '0;
    logic [15:0] sel_wr_data = '0;
    logic        base_wr_en = 1'b0;
    logic        base_wr_local = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic [1:0]  cpl = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [31:0] req_off = '0;
    logic        mem_rd_en, busy, lin_valid, fault_valid;
    logic [31:0] mem_rd_addr, mem_rd_data, lin_addr;
    logic [1:0]  fault_code;

    int    tests = 0, fails = 0;
    string cur_req = "R1";
    logic [31:0] mem [0:1023];
    logic [31:0] mem_q = '0;

    seg_xlate i_seg_xlate (.*);

    always #10 clk = ~clk;

    always @(posedge clk) if (mem_rd_en) mem_q <= mem[mem_rd_addr[11:2]];
    assign mem_rd_data = mem_q;

    // behavioural reference model
    logic [15:0] m_sel [6];
    logic [31:0] m_gdt, m_ldt, m_daddr, m_lin, p_lin;
    int          m_busy;
    bit          m_lv, m_fv, p_ok;
    int          m_code, p_code;

    always @(posedge clk) begin
        logic [15:0] s;
        logic [31:0] w0, w1;
        int          eff, dpl;
        if (!rst_n) begin
            m_busy = 0; m_lv = 0; m_fv = 0; m_code = 0; m_lin = 0;
            m_gdt = 0; m_ldt = 0; m_daddr = 0;
            for (int i = 0; i < 6; i++) m_sel[i] = 0;
        end else begin
            m_lv = 0; m_fv = 0;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    if (p_ok) begin m_lv = 1; m_lin = p_lin; end
                    else begin m_fv = 1; m_code = p_code; end
                end
            end else if (req_valid) begin
                s = (req_seg < 6) ? m_sel[req_seg] : 16'd0;
                if (s[15:3] == 0) begin
                    m_fv = 1; m_code = 1;
                end else begin
                    m_daddr = (s[2] ? m_ldt : m_gdt) + 32'(s[15:3]) * 8;
                    w0 = mem[m_daddr[11:2]];
                    w1 = mem[m_daddr[11:2] + 10'd1];
                    eff = (int'(s[1:0]) > int'(cpl)) ? int'(s[1:0]) : int'(cpl);
                    dpl = int'(w1[22:21]);
                    p_lin = w0 + req_off;
                    p_ok = 0;
                    if (dpl < eff) p_code = 2;
                    else if (req_off > {12'd0, w1[19:0]}) p_code = 3;
                    else p_ok = 1;
                    m_busy = 3;
                end
            end
            if (sel_wr_en && sel_wr_idx < 6) m_sel[sel_wr_idx] = sel_wr_data;
            if (base_wr_en) begin
                if (base_wr_local) m_ldt = base_wr_data; else m_gdt = base_wr_data;
            end
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        bit      rd_exp;
        logic [31:0] a_exp;
        rd_exp = (m_busy == 3) || (m_busy == 2);
        a_exp  = m_daddr + ((m_busy == 2) ? 32'd4 : 32'd0);
        check(busy == (m_busy != 0), "busy", 32'(busy), 32'(m_busy != 0));
        check(lin_valid == m_lv, "lin_valid", 32'(lin_valid), 32'(m_lv));
        check(fault_valid == m_fv, "fault_valid", 32'(fault_valid), 32'(m_fv));
        check(mem_rd_en == rd_exp, "mem_rd_en", 32'(mem_rd_en), 32'(rd_exp));
        if (m_lv) check(lin_addr == m_lin, "lin_addr", lin_addr, m_lin);
        if (m_fv) check(fault_code == 2'(m_code), "fault_code", 32'(fault_code), 32'(m_code));
        if (rd_exp) check(mem_rd_addr == a_exp, "mem_rd_addr", mem_rd_addr, a_exp);
    end

    task automatic put_desc(input logic [31:0] tbl, input int idx, input logic [31:0] base,
                            input logic [19:0] lim, input logic [1:0] dpl);
        logic [31:0] a;
        a = tbl + 32'(idx) * 8;
        mem[a[11:2]]         = base;
        mem[a[11:2] + 10'd1] = {9'd0, dpl, 1'b0, lim};
    endtask

    task automatic wr_sel(input logic [2:0] n, input logic [12:0] idx, input bit ti, input logic [1:0] rpl);
        @(negedge clk);
        sel_wr_en = 1; sel_wr_idx = n; sel_wr_data = {idx, ti, rpl};
        @(negedge clk);
        sel_wr_en = 0;
    endtask

    task automatic wr_base(input bit loc, input logic [31:0] v);
        @(negedge clk);
        base_wr_en = 1; base_wr_local = loc; base_wr_data = v;
        @(negedge clk);
        base_wr_en = 0;
    endtask

    task automatic xlate(input logic [2:0] seg, input logic [31:0] off, input logic [1:0] lvl);
        @(negedge clk);
        req_valid = 1; req_seg = seg; req_off = off; cpl = lvl;
        @(negedge clk);
        req_valid = 0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        put_desc(32'h100, 1, 32'h1000_0000, 20'hFFFFF, 2'd3);
        put_desc(32'h100, 2, 32'h0040_0000, 20'h00100, 2'd0);
        put_desc(32'h100, 3, 32'hFFFF_F000, 20'hFFFFF, 2'd3);
        put_desc(32'h800, 1, 32'h2000_0000, 20'h00FFF, 2'd2);
        put_desc(32'h800, 5, 32'h0000_0000, 20'h00010, 2'd0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        check(!busy && !lin_valid && !fault_valid && !mem_rd_en && fault_code == 0,
              "reset outputs", {busy, lin_valid, fault_valid, mem_rd_en, fault_code}, 32'd0);

        cur_req = "R11";
        wr_base(0, 32'h100);
        wr_base(1, 32'h800);
        cur_req = "R2";
        wr_sel(0, 13'd1, 0, 2'd0);
        wr_sel(1, 13'd2, 0, 2'd0);
        wr_sel(2, 13'd1, 1, 2'd0);
        wr_sel(3, 13'd0, 0, 2'd0);
        wr_sel(4, 13'd0, 1, 2'd3);
        wr_sel(5, 13'd3, 0, 2'd3);

        cur_req = "R5"; xlate(0, 32'h0000_1234, 2'd0);
        cur_req = "R3"; xlate(2, 32'h0000_0ABC, 2'd1);
        cur_req = "R4"; xlate(1, 32'h0000_0010, 2'd0);
        cur_req = "R5"; xlate(5, 32'h0000_2000, 2'd3);
        cur_req = "R7"; xlate(3, 32'h0, 2'd0);
        cur_req = "R7"; xlate(4, 32'h0, 2'd0);
        cur_req = "R8"; xlate(1, 32'h0, 2'd3);
        cur_req = "R8"; xlate(2, 32'h0, 2'd2);
        wr_sel(2, 13'd1, 1, 2'd3);
        cur_req = "R8"; xlate(2, 32'h0, 2'd0);
        cur_req = "R9"; xlate(1, 32'h0000_0100, 2'd0);
        cur_req = "R9"; xlate(1, 32'h0000_0101, 2'd0);
        wr_sel(3, 13'd5, 1, 2'd0);
        cur_req = "R10"; xlate(3, 32'h0000_0011, 2'd1);
        cur_req = "R10"; xlate(3, 32'h0000_0011, 2'd0);

        cur_req = "R6";
        @(negedge clk);
        req_valid = 1; req_seg = 0; req_off = 32'h44; cpl = 0;
        @(negedge clk); req_seg = 4;
        @(negedge clk); req_seg = 1;
        @(negedge clk); req_valid = 0;
        repeat (5) @(negedge clk);

        cur_req = "R2";
        wr_sel(0, 13'd2, 0, 2'd0);
        xlate(0, 32'h0000_0008, 2'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule